// File: doc/BRIEF.md
# PCI Configuration Access Sequencer

This block performs a single PCI configuration read or write on behalf of a local-bus host. It works through an outbound address translator, which has several base/map window pairs. Those windows are normally all given over to PCI memory, so there is no spare window for configuration space. The sequencer borrows window 1. First it enlarges window 0 so that window 0 covers the range window 1 normally serves. It then retargets window 1 at configuration space and issues the access through the local-bus master port. Last, it returns window 1 to prefetchable memory and shrinks window 0 back to its normal size. Because the translator picks the lowest-numbered window that matches, prefetchable memory stays reachable for the whole sequence.

The caller supplies a bus number, a device/function byte, a register offset, an access size and, for writes, the write data. The sequencer builds the configuration address from these fields. On bus 0 the device select is a one-hot bit, placed in the address for low slots and in the map value for high slots. On any other bus the bus number and device/function byte go directly into the address. A request with an out-of-range field gets a single-cycle error pulse. It causes no register writes and no bus traffic.

Top module: `cfg_access_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `reg_we` and `lb_valid` are all low.
- R2: The sequence opens with three register writes on consecutive cycles. Register select codes are 0 for base 0, 1 for base 1 and 2 for map 1. The writes are, in order: base 0 ← 0x4000_0091 (512 MB, non-prefetchable, enabled), then base 1 ← 0x6800_0041 (16 MB configuration window, enabled), then map 1 ← the configuration map value.
- R3: After the bus access, the sequence closes with three register writes, in order: base 1 ← 0x5000_0085, then map 1 ← 0x0000_1006, then base 0 ← 0x4000_0081. `done` pulses in the cycle after the last of these writes.
- R4: On bus 0 with slot (device/function bits 7:3) of 12 or less, the bus address is 0x6800_0000 + (1 << (slot+11)) + (function << 8) + offset, and the map value is 0x000A.
- R5: On bus 0 with slot above 12, the address carries no device bit. The map value is 0x000A | (1 << (slot−4)), truncated to 16 bits.
- R6: On a nonzero bus, the address is 0x6800_0000 + (bus << 16) + (devfn << 8) + offset, and the map value is 0x000B.
- R7: A request is rejected if its bus, device/function or offset exceeds 255, or if its size code is 3. A rejected request pulses `err` for one cycle in the cycle after acceptance, with no `done`, no register write and no bus access.
- R8: A configuration write is followed by a read from the same address before the close writes begin. `rdata` returns the data of that read.
- R9: The access size code is carried unchanged on `lb_size`: 0 for a byte, 1 for 16 bits, 2 for 32 bits. For a read, `rdata` is the data returned by the single bus read.
- R10: While `busy` is high, `req_valid` is ignored. `done` lasts exactly one cycle, and `rdata` is valid while `done` is high.
- R11: Once `lb_valid` is raised, it stays high with `lb_addr` unchanged until a cycle in which `lb_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 for a configuration write |
| req_bus | input | IDX_W | Bus number |
| req_devfn | input | IDX_W | Device (7:3) and function (2:0) |
| req_off | input | IDX_W | Register offset |
| req_size | input | 2 | 0 byte, 1 half, 2 word |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| rdata | output | 32 | Read data, valid with done |
| reg_we | output | 1 | Translator register write strobe |
| reg_sel | output | 2 | Translator register select |
| reg_wdata | output | 32 | Translator register data |
| lb_valid | output | 1 | Local-bus access request |
| lb_write | output | 1 | Local-bus write |
| lb_addr | output | 32 | Local-bus address |
| lb_size | output | 2 | Local-bus access size |
| lb_wdata | output | 32 | Local-bus write data |
| lb_ready | input | 1 | Local-bus access completes |
| lb_rdata | input | 32 | Local-bus read data |

## Verification
The address builder is driven with three bus-0 cases: a low slot, slot 12 (the last slot whose select bit lands in the address) and slot 13 (the first whose select bit lands in the map value). Together these separate the two placements of the one-hot select and catch an off-by-one at the boundary. A nonzero bus with a write shows that the type 1 layout is used and that the write is followed by a read of the same address. A 16-bit read with wait states checks the size field and the handshake. Requests that break each range limit, one at a time, must produce an error with no side effects. A request held during a busy sequence must leave the register-write log unchanged.

// File: rtl/cfg_access_seq.sv
module cfg_access_seq #(
  parameter logic [31:0] MEM_LOCAL = 32'h4000_0000,
  parameter logic [31:0] CFG_LOCAL = 32'h6800_0000,
  parameter logic [31:0] PREF_BUS  = 32'h1000_0000,
  parameter int          IDX_W     = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [IDX_W-1:0] req_bus,
  input  logic [IDX_W-1:0] req_devfn,
  input  logic [IDX_W-1:0] req_off,
  input  logic [1:0]       req_size,
  input  logic [31:0]      req_wdata,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [31:0]      rdata,
  output logic             reg_we,
  output logic [1:0]       reg_sel,
  output logic [31:0]      reg_wdata,
  output logic             lb_valid,
  output logic             lb_write,
  output logic [31:0]      lb_addr,
  output logic [1:0]       lb_size,
  output logic [31:0]      lb_wdata,
  input  logic             lb_ready,
  input  logic [31:0]      lb_rdata
);
  localparam logic [31:0] MB_MASK    = 32'hFFF0_0000;
  localparam logic [31:0] SZ_256M    = 32'h1000_0000;
  localparam logic [31:0] BASE0_WIDE = (MEM_LOCAL & MB_MASK) | 32'h91;
  localparam logic [31:0] BASE0_STD  = (MEM_LOCAL & MB_MASK) | 32'h81;
  localparam logic [31:0] BASE1_CFG  = (CFG_LOCAL & MB_MASK) | 32'h41;
  localparam logic [31:0] BASE1_PREF = ((MEM_LOCAL + SZ_256M) & MB_MASK) | 32'h85;
  localparam logic [31:0] MAP1_PREF  = ((PREF_BUS & MB_MASK) >> 16) | 32'h6;
  localparam logic [1:0]  SEL_B0 = 2'd0, SEL_B1 = 2'd1, SEL_M1 = 2'd2;
  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(256);

  typedef enum logic [3:0] {
    S_IDLE, S_OPEN0, S_OPEN1, S_OPENM, S_XFER, S_VERIFY, S_CLOSE1, S_CLOSEM, S_CLOSE0
  } st_t;

  st_t         st;
  logic        wr_q;
  logic [1:0]  size_q;
  logic [31:0] wdata_q, addr_q;
  logic [15:0] map_q;

  logic [4:0]  slot;
  logic [2:0]  func;
  logic        bad;
  logic [31:0] cfg_a;
  logic [15:0] cfg_m;

  assign slot = req_devfn[7:3];
  assign func = req_devfn[2:0];
  assign bad  = (req_bus >= LIMIT) || (req_devfn >= LIMIT) ||
                (req_off >= LIMIT) || (req_size == 2'd3);

  always_comb begin
    if (req_bus[7:0] == 8'd0) begin
      cfg_a = {21'b0, func, 8'b0};
      cfg_m = 16'h000A;
      if (slot > 5'd12) cfg_m = cfg_m | (16'h1 << (slot - 5'd4));
      else              cfg_a = cfg_a | (32'h1 << (slot + 5'd11));
    end else begin
      cfg_a = {8'b0, req_bus[7:0], req_devfn[7:0], 8'b0};
      cfg_m = 16'h000B;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      wr_q    <= 1'b0;
      size_q  <= 2'd0;
      wdata_q <= '0;
      addr_q  <= '0;
      map_q   <= '0;
      rdata   <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (bad) err <= 1'b1;
          else begin
            wr_q    <= req_write;
            size_q  <= req_size;
            wdata_q <= req_wdata;
            addr_q  <= CFG_LOCAL + cfg_a + {24'b0, req_off[7:0]};
            map_q   <= cfg_m;
            st      <= S_OPEN0;
          end
        end
        S_OPEN0:  st <= S_OPEN1;
        S_OPEN1:  st <= S_OPENM;
        S_OPENM:  st <= S_XFER;
        S_XFER: if (lb_ready) begin
          if (wr_q) st <= S_VERIFY;
          else begin
            rdata <= lb_rdata;
            st    <= S_CLOSE1;
          end
        end
        S_VERIFY: if (lb_ready) begin
          rdata <= lb_rdata;
          st    <= S_CLOSE1;
        end
        S_CLOSE1: st <= S_CLOSEM;
        S_CLOSEM: st <= S_CLOSE0;
        S_CLOSE0: begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
        default:  st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign lb_valid = (st == S_XFER) || (st == S_VERIFY);
  assign lb_write = (st == S_XFER) && wr_q;
  assign lb_addr  = addr_q;
  assign lb_size  = size_q;
  assign lb_wdata = wdata_q;

  always_comb begin
    reg_we    = 1'b1;
    reg_sel   = SEL_B0;
    reg_wdata = '0;
    case (st)
      S_OPEN0:  begin reg_sel = SEL_B0; reg_wdata = BASE0_WIDE; end
      S_OPEN1:  begin reg_sel = SEL_B1; reg_wdata = BASE1_CFG; end
      S_OPENM:  begin reg_sel = SEL_M1; reg_wdata = {16'b0, map_q}; end
      S_CLOSE1: begin reg_sel = SEL_B1; reg_wdata = BASE1_PREF; end
      S_CLOSEM: begin reg_sel = SEL_M1; reg_wdata = MAP1_PREF; end
      S_CLOSE0: begin reg_sel = SEL_B0; reg_wdata = BASE0_STD; end
      default:  reg_we = 1'b0;
    endcase
  end

  // R2
  open_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_B1 && reg_wdata == BASE1_CFG) |->
      $past(reg_we && reg_sel == SEL_B0 && reg_wdata == BASE0_WIDE));

  // R3
  close_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_B0 && reg_wdata == BASE0_STD) |->
      $past(reg_we && reg_sel == SEL_M1 && reg_wdata == MAP1_PREF));

  // R3
  done_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(reg_we && reg_sel == SEL_B0 && reg_wdata == BASE0_STD));

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!done && !reg_we && !lb_valid));

  // R8
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_valid && lb_write && lb_ready) |=> (lb_valid && !lb_write && $stable(lb_addr)));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_valid && !lb_ready) |=> (lb_valid && $stable(lb_addr)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && lb_valid));
endmodule

// File: tb/cfg_access_seq_test.sv
module cfg_access_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [8:0]  req_bus = '0, req_devfn = '0, req_off = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, done, err;
  logic [31:0] rdata;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic        lb_valid, lb_write;
  logic [31:0] lb_addr, lb_wdata;
  logic [1:0]  lb_size;
  logic        lb_ready = 1'b0;
  logic [31:0] lb_rdata = '0;

  cfg_access_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bus(req_bus), .req_devfn(req_devfn), .req_off(req_off),
    .req_size(req_size), .req_wdata(req_wdata), .busy(busy), .done(done),
    .err(err), .rdata(rdata), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .lb_valid(lb_valid), .lb_write(lb_write),
    .lb_addr(lb_addr), .lb_size(lb_size), .lb_wdata(lb_wdata),
    .lb_ready(lb_ready), .lb_rdata(lb_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0, cycles = 0, stall = 0, wcnt = 0;
  int nreg = 0, nlb = 0;
  logic [1:0]  rsel [16];
  logic [31:0] rdat [16];
  logic [31:0] laddr [8];
  logic        lwr [8];
  logic [1:0]  lsz [8];
  logic [31:0] lwd [8];

  function automatic logic [31:0] model(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (reg_we && nreg < 16) begin rsel[nreg] = reg_sel; rdat[nreg] = reg_wdata; nreg++; end
    if (lb_valid && lb_ready && nlb < 8) begin
      laddr[nlb] = lb_addr; lwr[nlb] = lb_write; lsz[nlb] = lb_size; lwd[nlb] = lb_wdata; nlb++;
    end
  end

  always @(negedge clk) begin
    if (lb_ready) begin lb_ready = 1'b0; wcnt = 0; end
    else if (lb_valid) begin
      if (wcnt >= stall) begin lb_ready = 1'b1; lb_rdata = model(lb_addr); end
      else wcnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    finish_run();
  end

  task automatic run(input logic [8:0] b, input logic [8:0] d, input logic [8:0] o,
                     input logic [1:0] sz, input logic w, input logic [31:0] wd,
                     output bit got_done, output bit got_err, output logic [31:0] rd);
    nreg = 0; nlb = 0; got_done = 0; got_err = 0; rd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_bus = b; req_devfn = d; req_off = o;
    req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 300 && !got_done && !got_err; i++) begin
      if (done) begin got_done = 1; rd = rdata; end
      else if (err) got_err = 1;
      else @(negedge clk);
    end
    @(negedge clk);
    chk(!done && !err, "R10 pulse one cycle", {30'b0, done, err}, 32'h0);
  endtask

  task automatic check_regs(input logic [15:0] map);
    chk(nreg == 6, "R2 register write count", nreg, 6);
    chk(rsel[0] == 2'd0 && rdat[0] == 32'h4000_0091, "R2 widen base0", rdat[0], 32'h4000_0091);
    chk(rsel[1] == 2'd1 && rdat[1] == 32'h6800_0041, "R2 base1 config", rdat[1], 32'h6800_0041);
    chk(rsel[2] == 2'd2 && rdat[2] == {16'b0, map}, "R2 map1 config", rdat[2], {16'b0, map});
    chk(rsel[3] == 2'd1 && rdat[3] == 32'h5000_0085, "R3 base1 restore", rdat[3], 32'h5000_0085);
    chk(rsel[4] == 2'd2 && rdat[4] == 32'h0000_1006, "R3 map1 restore", rdat[4], 32'h0000_1006);
    chk(rsel[5] == 2'd0 && rdat[5] == 32'h4000_0081, "R3 shrink base0", rdat[5], 32'h4000_0081);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err && !reg_we && !lb_valid, "R1 reset state",
        {27'b0, busy, done, err, reg_we, lb_valid}, 32'h0);
  endtask

  task automatic t_type0_low();
    bit dn, er; logic [31:0] rd, ea;
    ea = 32'h6800_0000 + (32'h1 << 14) + (32'h2 << 8) + 32'h10;
    run(9'd0, {1'b0, 5'd3, 3'd2}, 9'h10, 2'd2, 1'b0, '0, dn, er, rd);
    chk(dn && !er, "R10 done on read", {30'b0, dn, er}, 32'h2);
    check_regs(16'h000A);
    chk(nlb == 1 && laddr[0] == ea && !lwr[0], "R4 low slot address", laddr[0], ea);
    chk(lsz[0] == 2'd2, "R9 word size", {30'b0, lsz[0]}, 32'h2);
    chk(rd == model(ea), "R9 read data", rd, model(ea));
  endtask

  task automatic t_slot_edges();
    bit dn, er; logic [31:0] rd, ea;
    ea = 32'h6800_0000 + (32'h1 << 23) + (32'h7 << 8) + 32'h4;
    run(9'd0, {1'b0, 5'd12, 3'd7}, 9'h4, 2'd2, 1'b0, '0, dn, er, rd);
    chk(laddr[0] == ea, "R4 slot 12 address", laddr[0], ea);
    chk(rdat[2] == 32'h000A, "R4 slot 12 map", rdat[2], 32'h000A);
    ea = 32'h6800_0000 + (32'h1 << 8) + 32'hFC;
    run(9'd0, {1'b0, 5'd13, 3'd1}, 9'hFC, 2'd2, 1'b0, '0, dn, er, rd);
    chk(laddr[0] == ea, "R5 slot 13 address", laddr[0], ea);
    chk(rdat[2] == 32'h020A, "R5 slot 13 map", rdat[2], 32'h020A);
    chk(dn, "R5 done", {31'b0, dn}, 32'h1);
  endtask

  task automatic t_type1_write();
    bit dn, er; logic [31:0] rd, ea;
    ea = 32'h6800_0000 + (32'h5 << 16) + (32'h4B << 8) + 32'h3C;
    run(9'd5, 9'h4B, 9'h3C, 2'd0, 1'b1, 32'hDEAD_BEEF, dn, er, rd);
    check_regs(16'h000B);
    chk(nlb == 2, "R8 two bus accesses", nlb, 2);
    chk(laddr[0] == ea && lwr[0] && lwd[0] == 32'hDEAD_BEEF, "R6 type1 write address", laddr[0], ea);
    chk(laddr[1] == ea && !lwr[1], "R8 readback same address", laddr[1], ea);
    chk(lsz[0] == 2'd0 && lsz[1] == 2'd0, "R9 byte size", {30'b0, lsz[1]}, 32'h0);
    chk(rd == model(ea), "R8 readback data", rd, model(ea));
  endtask

  task automatic t_half_stall();
    bit dn, er; logic [31:0] rd, ea;
    stall = 3;
    ea = 32'h6800_0000 + (32'hFF << 16) + (32'h08 << 8) + 32'h02;
    run(9'd255, 9'h08, 9'h02, 2'd1, 1'b0, '0, dn, er, rd);
    chk(nlb == 1 && laddr[0] == ea, "R11 stalled access address", laddr[0], ea);
    chk(lsz[0] == 2'd1, "R9 half size", {30'b0, lsz[0]}, 32'h1);
    chk(rd == model(ea), "R11 stalled read data", rd, model(ea));
    stall = 0;
  endtask

  task automatic t_reject();
    bit dn, er; logic [31:0] rd;
    run(9'd0, 9'h08, 9'd256, 2'd2, 1'b0, '0, dn, er, rd);
    chk(er && !dn && nreg == 0 && nlb == 0, "R7 offset 256 rejected", {nreg[29:0], dn, er}, 32'h1);
    run(9'd256, 9'h08, 9'd0, 2'd2, 1'b1, '0, dn, er, rd);
    chk(er && !dn && nreg == 0 && nlb == 0, "R7 bus 256 rejected", {nreg[29:0], dn, er}, 32'h1);
    run(9'd1, 9'd300, 9'd0, 2'd2, 1'b0, '0, dn, er, rd);
    chk(er && !dn && nreg == 0 && nlb == 0, "R7 devfn 300 rejected", {nreg[29:0], dn, er}, 32'h1);
    run(9'd1, 9'd8, 9'd0, 2'd3, 1'b0, '0, dn, er, rd);
    chk(er && !dn && nreg == 0 && nlb == 0, "R9 size 3 rejected", {nreg[29:0], dn, er}, 32'h1);
    run(9'd1, 9'd255, 9'd255, 2'd2, 1'b0, '0, dn, er, rd);
    chk(dn && !er, "R7 limit 255 accepted", {30'b0, dn, er}, 32'h2);
  endtask

  task automatic t_busy();
    logic [31:0] ea;
    ea = 32'h6800_0000 + (32'h1 << 11) + 32'h8;
    stall = 4; nreg = 0; nlb = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_bus = 9'd0; req_devfn = 9'h00;
    req_off = 9'h8; req_size = 2'd2;
    @(negedge clk);
    req_bus = 9'd7; req_devfn = 9'h20; req_off = 9'h40;
    repeat (4) @(negedge clk);
    chk(busy, "R10 busy during sequence", {31'b0, busy}, 32'h1);
    req_valid = 1'b0;
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(nreg == 6 && nlb == 1, "R10 request ignored while busy", nreg, 6);
    chk(laddr[0] == ea, "R10 first request served", laddr[0], ea);
    stall = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_type0_low();
    t_slot_edges();
    t_type1_write();
    t_half_stall();
    t_reject();
    t_busy();
    finish_run();
  end
endmodule